// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block holds the status byte of a serial flash device and makes the permission decisions that depend on it. It keeps a write-enable latch and a set of persistent protection settings: a three-bit protection level, a top/bottom placement bit and a lock bit. A busy flag from the write engine is passed straight into the status byte. The command decoder sends single-cycle strobes for write-enable, write-disable, program/erase completion and status-write commit. The write engine gets a combinational verdict on whether a program or erase aimed at a given address may proceed.

A status write is gated by the latch and by the lock bit. The lock bit only has force while the hardware write-protect pin is held low. The protection level selects none, the upper or lower eighth, quarter or half, or the whole array. The verdict for a target address covers the whole unit the operation touches: a page, a sector, a block or the entire array.

Top module: `flash_status_guard`

## Requirements
- R1: `status_o` bit 0 is busy, bit 1 the write-enable latch, bits 4:2 the protection level (bit 4 the most significant), bit 5 the placement bit (0 = top, 1 = bottom), bit 6 always 0, and bit 7 the lock bit. After reset every stored bit is 0.
- R2: A `wren_i` pulse sets the latch. A `wrdi_i`, `op_done_i` or `wrsr_commit_i` pulse clears it. When a clear and a set arrive in the same cycle, the clear wins. The new value shows in the cycle after the strobe.
- R3: A status write committed while `wp_n` is low and the lock bit is 1 leaves bits 7 and 5:2 unchanged.
- R4: A status write committed with the latch at 1, and with `wp_n` high or the lock bit at 0, loads data bits 7 and 5:2 into the same positions. Data bits 0, 1 and 6 are ignored. A commit with the latch at 0 changes nothing.
- R5: While `wp_n` is low, the lock bit can go from 0 to 1 but never from 1 to 0. One permitted write may set the lock bit and change the level and placement together. With `wp_n` high, a permitted write can clear the lock bit.
- R6: Level 000 protects no address. Any level with bit 4 set protects the whole array.
- R7: Levels 001, 010 and 011 protect 1/8, 1/4 and 1/2 of the array. The placement bit puts that range at the highest addresses when 0 and at the lowest when 1.
- R8: `tgt_kind_i` encodes 0 = page program (256-byte page), 1 = sector erase (4 KiB), 2 = block erase (64 KiB), 3 = chip erase (whole array). `op_protected_o` is 1 when any byte of the aligned unit that contains `tgt_addr_i` lies in the protected range.
- R9: `op_allow_o` is 1 exactly when the latch is 1 and `op_protected_o` is 0. A chip erase is therefore refused whenever the level is non-zero. The placement bit alone does not block it.
- R10: Status bit 0 follows `busy_i` in the same cycle, with no register in between.

Top module ports (default `ADDR_W` = 19):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Hardware write-protect pin, low = lock bit has force |
| busy_i | input | 1 | Busy flag from the write engine |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| op_done_i | input | 1 | Program or erase completion strobe |
| wrsr_commit_i | input | 1 | Status-write commit strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| tgt_addr_i | input | ADDR_W | Target byte address of the program or erase |
| tgt_kind_i | input | 2 | Operation kind, encoded as in R8 |
| status_o | output | 8 | Status byte, laid out as in R1 |
| op_protected_o | output | 1 | Target unit overlaps the protected range |
| op_allow_o | output | 1 | Program or erase may proceed |

## Verification
The assertions assume each command strobe lasts one clock and that `wp_n`, the write data and the target inputs are steady across the clock edge where a commit is sampled. The bench changes every input only on the falling edge, so each rising edge sees settled values. It also mixes strobes that coincide in one cycle, because the clear-over-set priority is defined for that case. Target addresses are drawn at random and also placed directly on the fraction boundaries, so that units straddling or touching a boundary are exercised.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        TGT_PAGE   = 2'd0,
        TGT_SECTOR = 2'd1,
        TGT_BLOCK  = 2'd2,
        TGT_CHIP   = 2'd3
    } tgt_kind_e;

    typedef struct packed {
        logic       lock;
        logic       tb;
        logic [2:0] level;
    } prot_cfg_t;

    localparam int BIT_BUSY   = 0;
    localparam int BIT_WEL    = 1;
    localparam int BIT_LVL_LO = 2;
    localparam int BIT_TB     = 5;
    localparam int BIT_RSVD   = 6;
    localparam int BIT_LOCK   = 7;

    function automatic logic wrsr_permitted(logic wel, logic wp_n, logic lock);
        return wel && (wp_n || !lock);
    endfunction

    function automatic prot_cfg_t cfg_from_byte(logic [7:0] d);
        prot_cfg_t c;
        c.lock  = d[BIT_LOCK];
        c.tb    = d[BIT_TB];
        c.level = d[BIT_LVL_LO+2:BIT_LVL_LO];
        return c;
    endfunction

    function automatic logic [7:0] pack_status(prot_cfg_t c, logic wel, logic busy);
        logic [7:0] s;
        s                          = '0;
        s[BIT_BUSY]                = busy;
        s[BIT_WEL]                 = wel;
        s[BIT_LVL_LO+2:BIT_LVL_LO] = c.level;
        s[BIT_TB]                  = c.tb;
        s[BIT_RSVD]                = 1'b0;
        s[BIT_LOCK]                = c.lock;
        return s;
    endfunction

    // Number of leading address bits fixed for a partial fraction:
    // 1/8 -> 3, 1/4 -> 2, 1/2 -> 1.
    function automatic int unsigned span_shift(logic [1:0] frac);
        case (frac)
            2'd1:    return 3;
            2'd2:    return 2;
            2'd3:    return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fsg_status_regs.sv
module fsg_status_regs
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wp_n,
    input  logic       wren_i,
    input  logic       wrdi_i,
    input  logic       op_done_i,
    input  logic       wrsr_commit_i,
    input  logic [7:0] wrsr_data_i,
    output logic       wel_o,
    output prot_cfg_t  cfg_o
);

    logic      wel_q;
    prot_cfg_t cfg_q;
    logic      wel_clear;
    logic      cfg_load;

    assign wel_clear = wrdi_i || op_done_i || wrsr_commit_i;
    assign cfg_load  = wrsr_commit_i && wrsr_permitted(wel_q, wp_n, cfg_q.lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            if (cfg_load) begin
                cfg_q <= cfg_from_byte(wrsr_data_i);
            end
            if (wel_clear) begin
                wel_q <= 1'b0;
            end else if (wren_i) begin
                wel_q <= 1'b1;
            end
        end
    end

    assign wel_o = wel_q;
    assign cfg_o = cfg_q;

    a_r2_wel_clear: assert property (@(posedge clk) disable iff (rst)
        (wrdi_i || op_done_i || wrsr_commit_i) |=> !wel_q);

    a_r2_wel_set: assert property (@(posedge clk) disable iff (rst)
        (wren_i && !wrdi_i && !op_done_i && !wrsr_commit_i) |=> wel_q);

    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wrsr_commit_i && !wp_n && cfg_q.lock) |=> $stable(cfg_q));

    a_r4_no_latch_no_write: assert property (@(posedge clk) disable iff (rst)
        (wrsr_commit_i && !wel_q) |=> $stable(cfg_q));

    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && cfg_q.lock) |=> cfg_q.lock);

endmodule

// File: rtl/fsg_prot_region.sv
module fsg_prot_region
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  prot_cfg_t           cfg_i,
    output logic [ADDR_W-1:0]   region_lo_o,
    output logic [ADDR_W-1:0]   region_hi_o,
    output logic                region_any_o
);

    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] span;

    always_comb begin
        span         = ALL_ONES >> span_shift(cfg_i.level[1:0]);
        region_any_o = 1'b0;
        region_lo_o  = '0;
        region_hi_o  = '0;
        if (cfg_i.level[2]) begin
            region_any_o = 1'b1;
            region_lo_o  = '0;
            region_hi_o  = ALL_ONES;
        end else if (cfg_i.level[1:0] != 2'd0) begin
            region_any_o = 1'b1;
            if (cfg_i.tb) begin
                region_lo_o = '0;
                region_hi_o = span;
            end else begin
                region_lo_o = ~span;
                region_hi_o = ALL_ONES;
            end
        end
    end

endmodule

// File: rtl/fsg_target_check.sv
module fsg_target_check
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  tgt_kind_e         kind_i,
    input  logic [ADDR_W-1:0] region_lo_i,
    input  logic [ADDR_W-1:0] region_hi_i,
    input  logic              region_any_i,
    input  logic              wel_i,
    output logic              hit_o,
    output logic              allow_o
);

    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] page_mask;
    logic [ADDR_W-1:0] sect_mask;
    logic [ADDR_W-1:0] blk_mask;

    generate
        if (PAGE_W >= ADDR_W) begin : g_page_full
            assign page_mask = ALL_ONES;
        end else begin : g_page_part
            assign page_mask = ALL_ONES >> (ADDR_W - PAGE_W);
        end
        if (SECT_W >= ADDR_W) begin : g_sect_full
            assign sect_mask = ALL_ONES;
        end else begin : g_sect_part
            assign sect_mask = ALL_ONES >> (ADDR_W - SECT_W);
        end
        if (BLK_W >= ADDR_W) begin : g_blk_full
            assign blk_mask = ALL_ONES;
        end else begin : g_blk_part
            assign blk_mask = ALL_ONES >> (ADDR_W - BLK_W);
        end
    endgenerate

    logic [ADDR_W-1:0] unit_mask;
    logic [ADDR_W-1:0] unit_lo;
    logic [ADDR_W-1:0] unit_hi;

    always_comb begin
        case (kind_i)
            TGT_PAGE:   unit_mask = page_mask;
            TGT_SECTOR: unit_mask = sect_mask;
            TGT_BLOCK:  unit_mask = blk_mask;
            default:    unit_mask = ALL_ONES;
        endcase
        unit_lo = addr_i & ~unit_mask;
        unit_hi = addr_i | unit_mask;
        hit_o   = region_any_i && (unit_lo <= region_hi_i) && (unit_hi >= region_lo_i);
        allow_o = wel_i && !hit_o;
    end

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              busy_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              op_done_i,
    input  logic              wrsr_commit_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic [1:0]        tgt_kind_i,
    output logic [7:0]        status_o,
    output logic              op_protected_o,
    output logic              op_allow_o
);

    logic              wel;
    prot_cfg_t         cfg;
    logic [ADDR_W-1:0] reg_lo;
    logic [ADDR_W-1:0] reg_hi;
    logic              reg_any;
    tgt_kind_e         kind;

    assign kind = tgt_kind_e'(tgt_kind_i);

    fsg_status_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .wp_n          (wp_n),
        .wren_i        (wren_i),
        .wrdi_i        (wrdi_i),
        .op_done_i     (op_done_i),
        .wrsr_commit_i (wrsr_commit_i),
        .wrsr_data_i   (wrsr_data_i),
        .wel_o         (wel),
        .cfg_o         (cfg)
    );

    fsg_prot_region #(.ADDR_W(ADDR_W)) u_region (
        .cfg_i        (cfg),
        .region_lo_o  (reg_lo),
        .region_hi_o  (reg_hi),
        .region_any_o (reg_any)
    );

    fsg_target_check #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SECT_W (SECT_W),
        .BLK_W  (BLK_W)
    ) u_check (
        .addr_i       (tgt_addr_i),
        .kind_i       (kind),
        .region_lo_i  (reg_lo),
        .region_hi_i  (reg_hi),
        .region_any_i (reg_any),
        .wel_i        (wel),
        .hit_o        (op_protected_o),
        .allow_o      (op_allow_o)
    );

    assign status_o = pack_status(cfg, wel, busy_i);

    a_r6_level_zero_free: assert property (@(posedge clk) disable iff (rst)
        (status_o[4:2] == 3'b000) |-> !op_protected_o);

    a_r6_full_array: assert property (@(posedge clk) disable iff (rst)
        status_o[4] |-> op_protected_o);

    a_r9_chip_refused: assert property (@(posedge clk) disable iff (rst)
        ((tgt_kind_i == 2'd3) && (status_o[4:2] != 3'b000)) |-> !op_allow_o);

    a_r9_needs_latch: assert property (@(posedge clk) disable iff (rst)
        op_allow_o |-> status_o[1]);

endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;

    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst;
    logic              wp_n, busy, wren, wrdi, opd, com;
    logic [7:0]        wdat;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        kind;
    logic [7:0]        status_o;
    logic              prot_o, allow_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic       wel_m, lock_m, tb_m;
    logic [2:0] lvl_m;

    always #10 clk = ~clk;

    flash_status_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .wp_n           (wp_n),
        .busy_i         (busy),
        .wren_i         (wren),
        .wrdi_i         (wrdi),
        .op_done_i      (opd),
        .wrsr_commit_i  (com),
        .wrsr_data_i    (wdat),
        .tgt_addr_i     (addr),
        .tgt_kind_i     (kind),
        .status_o       (status_o),
        .op_protected_o (prot_o),
        .op_allow_o     (allow_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_prot(logic [ADDR_W-1:0] a, logic [1:0] k, logic [2:0] lvl, logic tb);
        longint arr, sz, plo, phi, usz, base;
        arr = longint'(1) << ADDR_W;
        if (lvl == 3'b000) return 0;
        if (lvl[2]) return 1;
        sz = arr >> (4 - int'(lvl[1:0]));
        if (tb) begin plo = 0; phi = sz - 1; end
        else begin plo = arr - sz; phi = arr - 1; end
        case (k)
            2'd0:    usz = 256;
            2'd1:    usz = 4096;
            2'd2:    usz = 65536;
            default: usz = arr;
        endcase
        if (usz > arr) usz = arr;
        base = (longint'(a) / usz) * usz;
        return (base <= phi) && (base + usz - 1 >= plo);
    endfunction

    function automatic logic [7:0] exp_status();
        return {lock_m, 1'b0, tb_m, lvl_m, wel_m, busy};
    endfunction

    task automatic clear_strobes();
        wren = 0; wrdi = 0; opd = 0; com = 0;
    endtask

    // Called just after a falling edge with inputs set.
    task automatic apply();
        bit ep, load;
        #1;
        chk(status_o == exp_status(), "R1 status byte", status_o, exp_status());
        ep = exp_prot(addr, kind, lvl_m, tb_m);
        chk(prot_o == ep, "R8 overlap", prot_o, ep);
        chk(allow_o == (wel_m && !ep), "R9 allow", allow_o, wel_m && !ep);
        @(posedge clk);
        load = com && wel_m && (wp_n || !lock_m);
        if (load) begin
            lock_m = wdat[7]; tb_m = wdat[5]; lvl_m = wdat[4:2];
        end
        if (wrdi || opd || com) wel_m = 0;
        else if (wren) wel_m = 1;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input logic [1:0] k);
        addr = a; kind = k; #1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1; wp_n = 1; busy = 0; wdat = 0; addr = 0; kind = 0;
        clear_strobes();
        wel_m = 0; lock_m = 0; tb_m = 0; lvl_m = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(status_o == 8'h00, "R1 reset state", status_o, 8'h00);
        @(negedge clk);

        // R10: busy visible same cycle
        busy = 1; #1;
        chk(status_o[0] == 1'b1, "R10 busy live", status_o[0], 1);
        busy = 0; #1;
        chk(status_o[0] == 1'b0, "R10 busy drop", status_o[0], 0);
        @(negedge clk);

        // R4: write with latch clear is ignored
        com = 1; wdat = 8'h9C; apply();
        chk(status_o == 8'h00, "R4 no latch write ignored", status_o, 8'h00);

        // R2: set and clear in same cycle -> clear wins
        wren = 1; wrdi = 1; apply();
        chk(status_o[1] == 1'b0, "R2 clear wins", status_o[1], 0);
        wren = 1; apply();
        chk(status_o[1] == 1'b1, "R2 latch set", status_o[1], 1);
        opd = 1; apply();
        chk(status_o[1] == 1'b0, "R2 completion clears", status_o[1], 0);

        // R5: with pin low set lock and level 001 at once; bits 0,1,6 ignored
        wp_n = 0;
        wren = 1; apply();
        com = 1; wdat = 8'hC7; apply();
        chk(status_o == 8'h84, "R5 lock and level together", status_o, 8'h84);

        // R7: top eighth
        look(19'h70000, 2'd1);
        chk(prot_o == 1'b1, "R7 top eighth start", prot_o, 1);
        look(19'h6F000, 2'd1);
        chk(prot_o == 1'b0, "R7 below top eighth", prot_o, 0);
        look(19'h60000, 2'd2);
        chk(prot_o == 1'b0, "R7 block below", prot_o, 0);
        @(negedge clk);

        // R3: locked with pin low
        wren = 1; apply();
        com = 1; wdat = 8'h00; apply();
        chk(status_o == 8'h84, "R3 locked write ignored", status_o, 8'h84);

        // R5: pin high allows unlocking; bottom half
        wp_n = 1;
        wren = 1; apply();
        com = 1; wdat = 8'h2C; apply();
        chk(status_o == 8'h2C, "R5 unlock with pin high", status_o, 8'h2C);
        look(19'h3FFFF, 2'd0);
        chk(prot_o == 1'b1, "R7 bottom half top byte", prot_o, 1);
        look(19'h40000, 2'd0);
        chk(prot_o == 1'b0, "R7 above bottom half", prot_o, 0);
        look(19'h40000, 2'd3);
        chk(prot_o == 1'b1, "R9 chip refused with level", prot_o, 1);
        @(negedge clk);

        // R6: placement bit only, chip erase allowed with latch
        wren = 1; apply();
        com = 1; wdat = 8'h20; apply();
        wren = 1; apply();
        look(19'h00000, 2'd3);
        chk(prot_o == 1'b0 && allow_o == 1'b1, "R6 R9 chip allowed level zero", {prot_o, allow_o}, 2'b01);
        @(negedge clk);

        // R6: whole array
        com = 1; wdat = 8'h10; apply();
        look(19'h12345, 2'd0);
        chk(prot_o == 1'b1, "R6 full array", prot_o, 1);
        @(negedge clk);

        // Random phase, checked against the model every cycle
        for (int i = 0; i < 600; i++) begin
            wp_n = ($urandom % 4) != 0;
            busy = $urandom % 2;
            wren = ($urandom % 3) == 0;
            wrdi = ($urandom % 10) == 0;
            opd  = ($urandom % 10) == 0;
            com  = ($urandom % 4) == 0;
            wdat = 8'($urandom);
            kind = 2'($urandom);
            case ($urandom % 4)
                0: addr = ADDR_W'($urandom);
                1: addr = ADDR_W'(((($urandom % 8) << 16)) - ($urandom % 2));
                2: addr = ADDR_W'((($urandom % 8) << 16) | 16'hFFFF);
                default: addr = ADDR_W'(($urandom % 8) << 16);
            endcase
            apply();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule